// File: doc/BRIEF.md
# MAC Frame Statistics Counter Bank

This block keeps the frame statistics of an Ethernet MAC and presents them on a small word-addressed register port. Two 48-bit counters accumulate transmitted and received octets from per-cycle byte amounts, and twelve 32-bit counters count events: frames sent, frames received, broadcast, multicast, frames with a bad frame check sequence, and seven received-length bins. The bins are sorted from a received length presented with a valid strobe. Frame parsing lies outside the block; every event arrives as an input strobe.

Every counter saturates at all ones and clears when its live value is read. Received-side counters move only while `rx_en` is high. A snapshot request copies every counter into a shadow set and clears the live set in one cycle, and `rd_snap_sel` steers reads to the shadow set, whose reads clear nothing. For test, `test_inc` adds one to every counter and `test_wr_en` lets the port write counter words. A 48-bit counter is read low word first: that read latches its upper 16 bits, and a following high-word read returns the latched value. The pairing is tracked by a state machine with states PAIR_NONE, PAIR_TX and PAIR_RX. A transmit low read moves any state to PAIR_TX, a receive low read moves any state to PAIR_RX, a high read of the counter that is held returns to PAIR_NONE, and every other read leaves the state unchanged.

Top module: `mac_stat_bank`

## Requirements
- R1: A read (`bus_rd` high) returns its data on `bus_rdata` with `bus_rvalid` high in the next cycle; with no read, `bus_rvalid` is low the next cycle.
- R2: A read of a live counter's low word (addresses 0, 2) or of an event counter (addresses 4 to 15) returns the value before the read and clears that counter.
- R3: A counter at all ones stays at all ones on further increments (0xFFFFFFFF for event counters, 0xFFFF_FFFFFFFF for octet counters).
- R4: With `rx_en` low, the received-octet counter and the counters at addresses 5 to 15 do not change on their strobes; the transmit counters (addresses 0, 1, 4) still count.
- R5: Reading address 0 (transmit octets) or 2 (received octets) latches that counter's bits 47:32; a later read of address 1 or 3 respectively returns the latched value and releases the pair. A high-word read with no pending low read of the same counter returns 0. Reads of event counters in between keep the pair.
- R6: A cycle with `snap_req` high copies every counter into the shadow set and leaves each live counter at that cycle's increment amount.
- R7: With `rd_snap_sel` high, reads return the shadow set and clear neither set.
- R8: A `test_inc` pulse adds one to every counter, whatever `rx_en` is.
- R9: With `test_wr_en` and `bus_wr` high, `bus_wdata` is written to the addressed word: bits 31:0 of an octet counter at an even address below 4, bits 47:32 from `bus_wdata[15:0]` at address 1 or 3, or the whole event counter at 4 to 15.
- R10: A `rx_len_vld` strobe with `rx_en` high increments exactly one bin: 64 bytes at address 9, 65–127 at 10, 128–255 at 11, 256–511 at 12, 512–1023 at 13, 1024–1518 at 14, 1519 and more at 15; lengths below 64 hit none.
- R11: An increment arriving in the same cycle as the clearing read leaves the counter at the increment amount.
- R12: After reset all counters, both shadow sets and `bus_rdata` are zero and `bus_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive-side counting enable |
| test_inc | input | 1 | Add one to every counter |
| test_wr_en | input | 1 | Allow port writes to counters |
| snap_req | input | 1 | Capture shadow set and clear live set |
| rd_snap_sel | input | 1 | Reads return shadow set when high |
| tx_oct_amt | input | AMT_W | Transmitted bytes this cycle |
| rx_oct_amt | input | AMT_W | Received bytes this cycle |
| tx_ok_stb | input | 1 | Frame sent |
| rx_ok_stb | input | 1 | Frame received |
| rx_bcast_stb | input | 1 | Broadcast frame received |
| rx_mcast_stb | input | 1 | Multicast frame received |
| rx_fcs_stb | input | 1 | Frame check sequence error |
| rx_len_vld | input | 1 | Received length is valid |
| rx_len | input | LEN_W | Received frame length in bytes |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| bus_rvalid | output | 1 | Read data valid |

## Verification
The hardest state to reach from the ports is a counter near 2^32 or 2^48, which no run could reach by counting; the bench loads values one or two below the limit through test writes, then pushes them over with test increments and octet amounts. The second awkward case is a strobe landing in the very cycle of a clearing read, which the bench creates by driving both in the same cycle. The length bins are swept over every length from 0 to 2047 plus the largest length, with bin totals computed arithmetically.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;

    // Which 48-bit counter has its upper word held for a high-word read.
    typedef enum logic [1:0] {
        PAIR_NONE = 2'd0,
        PAIR_TX   = 2'd1,
        PAIR_RX   = 2'd2
    } pair_state_e;

    localparam int STAT_NUM_BINS = 7;

    // Lowest frame length that falls into bin b.
    function automatic int unsigned bin_floor(input int b);
        if (b <= 0)
            return 64;
        else if (b == 1)
            return 65;
        else if (b < STAT_NUM_BINS - 1)
            return 32'd64 << (b - 1);
        else
            return 1519;
    endfunction

endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
    parameter int W     = 32,
    parameter int INC_W = 2,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    input  logic             clr,
    input  logic             snap,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [DW-1:0]    wr_data,
    output logic [W-1:0]     live,
    output logic [W-1:0]     shadow
);

    logic [W:0]   sum;
    logic [W-1:0] bumped;
    logic [W-1:0] wr_val;

    assign sum    = {1'b0, live} + (W+1)'(inc);
    assign bumped = sum[W] ? '1 : sum[W-1:0];

    generate
        if (W > DW) begin : g_wide
            always_comb begin
                wr_val = live;
                if (wr_lo) wr_val[DW-1:0] = wr_data;
                if (wr_hi) wr_val[W-1:DW] = wr_data[W-DW-1:0];
            end
            if (2*DW > W) begin : g_spare
                logic unused_hi_bits;
                assign unused_hi_bits = ^wr_data[DW-1:W-DW];
            end
        end else begin : g_narrow
            always_comb begin
                wr_val = live;
                if (wr_lo | wr_hi) wr_val = wr_data[W-1:0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live   <= '0;
            shadow <= '0;
        end else begin
            if (wr_lo | wr_hi)
                live <= wr_val;
            else if (clr | snap)
                live <= W'(inc);
            else
                live <= bumped;
            if (snap)
                shadow <= live;
        end
    end

endmodule

// File: rtl/len_binner.sv
module len_binner
    import stat_bank_pkg::*;
#(
    parameter int LEN_W    = 14,
    parameter int NUM_BINS = STAT_NUM_BINS
) (
    input  logic                len_vld,
    input  logic [LEN_W-1:0]    len,
    output logic [NUM_BINS-1:0] hit
);

    generate
        for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
            localparam logic [LEN_W-1:0] LO = LEN_W'(bin_floor(b));
            localparam logic [LEN_W-1:0] HI = (b == NUM_BINS - 1) ? '1
                                              : LEN_W'(bin_floor(b + 1) - 1);
            assign hit[b] = len_vld && (len >= LO) && (len <= HI);
        end
    endgenerate

endmodule

// File: rtl/pair_read_fsm.sv
module pair_read_fsm
    import stat_bank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HI_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_lo_tx,
    input  logic              rd_lo_rx,
    input  logic              rd_hi_tx,
    input  logic              rd_hi_rx,
    input  logic [HI_W-1:0]   tx_upper,
    input  logic [HI_W-1:0]   rx_upper,
    output pair_state_e       state,
    output logic [DATA_W-1:0] hi_word
);

    pair_state_e     state_nx;
    logic [HI_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PAIR_NONE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= '0;
        else if (rd_lo_tx) hold_q <= tx_upper;
        else if (rd_lo_rx) hold_q <= rx_upper;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PAIR_NONE: begin
                if (rd_lo_tx)      state_nx = PAIR_TX;
                else if (rd_lo_rx) state_nx = PAIR_RX;
            end
            PAIR_TX: begin
                if (rd_lo_tx)      state_nx = PAIR_TX;
                else if (rd_lo_rx) state_nx = PAIR_RX;
                else if (rd_hi_tx) state_nx = PAIR_NONE;
            end
            PAIR_RX: begin
                if (rd_lo_tx)      state_nx = PAIR_TX;
                else if (rd_lo_rx) state_nx = PAIR_RX;
                else if (rd_hi_rx) state_nx = PAIR_NONE;
            end
            default: state_nx = PAIR_NONE;
        endcase
    end

    always_comb begin
        hi_word = '0;
        unique case (state)
            PAIR_TX:   if (rd_hi_tx) hi_word = DATA_W'(hold_q);
            PAIR_RX:   if (rd_hi_rx) hi_word = DATA_W'(hold_q);
            default:   hi_word = '0;
        endcase
    end

endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
    import stat_bank_pkg::*;
#(
    parameter int OCT_W  = 48,
    parameter int EVT_W  = 32,
    parameter int AMT_W  = 4,
    parameter int LEN_W  = 14,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              test_inc,
    input  logic              test_wr_en,
    input  logic              snap_req,
    input  logic              rd_snap_sel,
    input  logic [AMT_W-1:0]  tx_oct_amt,
    input  logic [AMT_W-1:0]  rx_oct_amt,
    input  logic              tx_ok_stb,
    input  logic              rx_ok_stb,
    input  logic              rx_bcast_stb,
    input  logic              rx_mcast_stb,
    input  logic              rx_fcs_stb,
    input  logic              rx_len_vld,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid
);

    localparam int NUM_BINS  = STAT_NUM_BINS;
    localparam int NUM_FLAGS = 5;
    localparam int NUM_EVT   = NUM_FLAGS + NUM_BINS;
    localparam int NUM_OCT   = 2;
    localparam int EVT_BASE  = 2 * NUM_OCT;
    localparam int OCT_INC_W = AMT_W + 1;
    localparam int EVT_INC_W = 2;
    localparam int HI_W      = OCT_W - DATA_W;

    logic                live_rd;
    logic                test_wr;
    logic [NUM_BINS-1:0] bin_hit;
    logic [NUM_EVT-1:0]  evt_raw;
    logic [NUM_EVT-1:0]  evt_gate;
    logic [AMT_W-1:0]    oct_amt    [NUM_OCT];
    logic [OCT_W-1:0]    oct_live   [NUM_OCT];
    logic [OCT_W-1:0]    oct_shadow [NUM_OCT];
    logic [OCT_W-1:0]    oct_sel    [NUM_OCT];
    logic [NUM_OCT-1:0]  rd_lo;
    logic [NUM_OCT-1:0]  rd_hi;
    logic [EVT_W-1:0]    ev_live    [NUM_EVT];
    logic [EVT_W-1:0]    ev_shadow  [NUM_EVT];
    logic [EVT_W-1:0]    ev_sel     [NUM_EVT];
    pair_state_e         pair_q;
    logic [DATA_W-1:0]   hi_word;
    logic [DATA_W-1:0]   rd_mux;

    assign live_rd = bus_rd & ~rd_snap_sel;
    assign test_wr = bus_wr & test_wr_en;

    len_binner #(
        .LEN_W    (LEN_W),
        .NUM_BINS (NUM_BINS)
    ) u_bins (
        .len_vld (rx_len_vld),
        .len     (rx_len),
        .hit     (bin_hit)
    );

    // Index 0 is the only transmit-side event; all others need rx_en.
    assign evt_raw  = {bin_hit, rx_fcs_stb, rx_mcast_stb, rx_bcast_stb,
                       rx_ok_stb, tx_ok_stb};
    assign evt_gate = rx_en ? evt_raw : {{(NUM_EVT-1){1'b0}}, evt_raw[0]};

    assign oct_amt[0] = tx_oct_amt;
    assign oct_amt[1] = rx_en ? rx_oct_amt : '0;

    generate
        for (genvar j = 0; j < NUM_OCT; j++) begin : g_oct
            localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(2*j);
            localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(2*j + 1);
            logic [OCT_INC_W-1:0] inc;

            assign inc      = OCT_INC_W'(oct_amt[j]) + OCT_INC_W'(test_inc);
            assign rd_lo[j] = bus_rd && (bus_addr == LO_ADDR);
            assign rd_hi[j] = bus_rd && (bus_addr == HI_ADDR);

            stat_counter #(
                .W     (OCT_W),
                .INC_W (OCT_INC_W),
                .DW    (DATA_W)
            ) u_ctr (
                .clk     (clk),
                .rst_n   (rst_n),
                .inc     (inc),
                .clr     (live_rd && (bus_addr == LO_ADDR)),
                .snap    (snap_req),
                .wr_lo   (test_wr && (bus_addr == LO_ADDR)),
                .wr_hi   (test_wr && (bus_addr == HI_ADDR)),
                .wr_data (bus_wdata),
                .live    (oct_live[j]),
                .shadow  (oct_shadow[j])
            );

            assign oct_sel[j] = rd_snap_sel ? oct_shadow[j] : oct_live[j];
        end

        for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
            localparam logic [ADDR_W-1:0] EV_ADDR = ADDR_W'(EVT_BASE + i);
            logic [EVT_INC_W-1:0] inc;

            assign inc = EVT_INC_W'(evt_gate[i]) + EVT_INC_W'(test_inc);

            stat_counter #(
                .W     (EVT_W),
                .INC_W (EVT_INC_W),
                .DW    (DATA_W)
            ) u_ctr (
                .clk     (clk),
                .rst_n   (rst_n),
                .inc     (inc),
                .clr     (live_rd && (bus_addr == EV_ADDR)),
                .snap    (snap_req),
                .wr_lo   (test_wr && (bus_addr == EV_ADDR)),
                .wr_hi   (1'b0),
                .wr_data (bus_wdata),
                .live    (ev_live[i]),
                .shadow  (ev_shadow[i])
            );

            assign ev_sel[i] = rd_snap_sel ? ev_shadow[i] : ev_live[i];
        end
    endgenerate

    pair_read_fsm #(
        .DATA_W (DATA_W),
        .HI_W   (HI_W)
    ) u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_lo_tx (rd_lo[0]),
        .rd_lo_rx (rd_lo[1]),
        .rd_hi_tx (rd_hi[0]),
        .rd_hi_rx (rd_hi[1]),
        .tx_upper (oct_sel[0][OCT_W-1:DATA_W]),
        .rx_upper (oct_sel[1][OCT_W-1:DATA_W]),
        .state    (pair_q),
        .hi_word  (hi_word)
    );

    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NUM_OCT; k++)
            if (rd_lo[k]) rd_mux = oct_sel[k][DATA_W-1:0];
        if (|rd_hi) rd_mux = hi_word;
        for (int e = 0; e < NUM_EVT; e++)
            if (bus_addr == ADDR_W'(EVT_BASE + e)) rd_mux = DATA_W'(ev_sel[e]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            bus_rdata  <= bus_rd ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk
    import stat_bank_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int EVT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rd_snap_sel,
    input logic              test_inc,
    input logic              snap_req,
    input logic              rx_en,
    input logic              tx_ok_stb,
    input pair_state_e       pair_state,
    input logic              bus_rvalid,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [EVT_W-1:0]  tx_ok_live,
    input logic [DATA_W-1:0] rx_oct_low
);

    localparam logic [ADDR_W-1:0] A_TX_HI = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_TX_OK = ADDR_W'(4);

    assert_read_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ok_live == '1) && !snap_req && !bus_wr &&
        !(bus_rd && !rd_snap_sel && bus_addr == A_TX_OK)
        |=> tx_ok_live == '1);

    assert_rx_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en && !test_inc && !snap_req && !bus_wr && !bus_rd
        |=> $stable(rx_oct_low));

    assert_unpaired_high_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == A_TX_HI && pair_state != PAIR_TX
        |=> bus_rdata == '0);

    assert_snapshot_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req && !tx_ok_stb && !test_inc && !bus_wr
        |=> tx_ok_live == '0);

endmodule

bind mac_stat_bank stat_bank_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .EVT_W  (EVT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .rd_snap_sel (rd_snap_sel),
    .test_inc    (test_inc),
    .snap_req    (snap_req),
    .rx_en       (rx_en),
    .tx_ok_stb   (tx_ok_stb),
    .pair_state  (pair_q),
    .bus_rvalid  (bus_rvalid),
    .bus_rdata   (bus_rdata),
    .tx_ok_live  (ev_live[0]),
    .rx_oct_low  (oct_live[1][DATA_W-1:0])
);

// File: tb/tb_mac_stat_bank.sv
module tb_mac_stat_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic        test_inc = 1'b0;
    logic        test_wr_en = 1'b0;
    logic        snap_req = 1'b0;
    logic        rd_snap_sel = 1'b0;
    logic [3:0]  tx_oct_amt = '0;
    logic [3:0]  rx_oct_amt = '0;
    logic        tx_ok_stb = 1'b0;
    logic        rx_ok_stb = 1'b0;
    logic        rx_bcast_stb = 1'b0;
    logic        rx_mcast_stb = 1'b0;
    logic        rx_fcs_stb = 1'b0;
    logic        rx_len_vld = 1'b0;
    logic [13:0] rx_len = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    mac_stat_bank dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .test_inc(test_inc),
        .test_wr_en(test_wr_en), .snap_req(snap_req), .rd_snap_sel(rd_snap_sel),
        .tx_oct_amt(tx_oct_amt), .rx_oct_amt(rx_oct_amt),
        .tx_ok_stb(tx_ok_stb), .rx_ok_stb(rx_ok_stb), .rx_bcast_stb(rx_bcast_stb),
        .rx_mcast_stb(rx_mcast_stb), .rx_fcs_stb(rx_fcs_stb),
        .rx_len_vld(rx_len_vld), .rx_len(rx_len),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 50000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=<50000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, input logic ssel, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; rd_snap_sel = ssel;
        @(negedge clk);
        bus_rd = 1'b0; rd_snap_sel = 1'b0;
        d = bus_rdata;
        if (bus_rvalid !== 1'b1) begin
            checks++; errors++;
            $display("FAIL R1: actual rvalid=%0b expected=1", bus_rvalid);
        end
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic ssel,
                          input logic [31:0] exp);
        logic [31:0] d;
        rd(a, ssel, d);
        check(req, {16'h0, d}, {16'h0, exp});
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; test_wr_en = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0; test_wr_en = 1'b0;
    endtask

    function automatic int bin_of(input int len);
        if (len < 64)   return -1;
        if (len == 64)  return 0;
        if (len < 128)  return 1;
        if (len < 256)  return 2;
        if (len < 512)  return 3;
        if (len < 1024) return 4;
        if (len < 1519) return 5;
        return 6;
    endfunction

    task automatic pulse_all_events(input logic [3:0] ta, input logic [3:0] ra);
        @(negedge clk);
        tx_oct_amt = ta; rx_oct_amt = ra;
        tx_ok_stb = 1; rx_ok_stb = 1; rx_bcast_stb = 1; rx_mcast_stb = 1; rx_fcs_stb = 1;
        rx_len_vld = 1; rx_len = 14'd100;
        @(negedge clk);
        tx_oct_amt = 0; rx_oct_amt = 0;
        tx_ok_stb = 0; rx_ok_stb = 0; rx_bcast_stb = 0; rx_mcast_stb = 0; rx_fcs_stb = 0;
        rx_len_vld = 0;
    endtask

    initial begin
        int exp_bin [7];
        logic [31:0] d;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state at the port and in every counter
        check("R12 rvalid", {47'h0, bus_rvalid}, 48'h0);
        check("R12 rdata", {16'h0, bus_rdata}, 48'h0);
        for (int a = 0; a < 16; a++) rd_chk("R12 counter", a[3:0], 1'b0, 32'h0);
        rd_chk("R12 shadow", 4'd4, 1'b1, 32'h0);

        // R10: sweep every length 0..2047 plus the largest one
        for (int b = 0; b < 7; b++) exp_bin[b] = 0;
        rx_en = 1'b1;
        for (int l = 0; l <= 2048; l++) begin
            int len;
            len = (l == 2048) ? 16383 : l;
            @(negedge clk);
            rx_len_vld = 1'b1; rx_len = len[13:0];
            if (bin_of(len) >= 0) exp_bin[bin_of(len)]++;
        end
        @(negedge clk);
        rx_len_vld = 1'b0;
        for (int b = 0; b < 7; b++) rd_chk("R10 bin count", 4'(9 + b), 1'b0, 32'(exp_bin[b]));
        // R2: those reads cleared the bins
        for (int b = 0; b < 7; b++) rd_chk("R2 cleared after read", 4'(9 + b), 1'b0, 32'h0);
        rd_chk("R10 rx_ok untouched", 4'd5, 1'b0, 32'h0);

        // R4: receive gating
        rx_en = 1'b0;
        pulse_all_events(4'd3, 4'd5);
        rd_chk("R4 tx octets count", 4'd0, 1'b0, 32'd3);
        rd_chk("R4 rx octets frozen", 4'd2, 1'b0, 32'd0);
        rd_chk("R4 tx frames count", 4'd4, 1'b0, 32'd1);
        for (int a = 5; a <= 8; a++) rd_chk("R4 rx event frozen", a[3:0], 1'b0, 32'd0);
        rd_chk("R4 rx bin frozen", 4'd10, 1'b0, 32'd0);
        rx_en = 1'b1;
        pulse_all_events(4'd3, 4'd5);
        rd_chk("R4 rx octets count", 4'd2, 1'b0, 32'd5);
        for (int a = 5; a <= 8; a++) rd_chk("R4 rx event count", a[3:0], 1'b0, 32'd1);
        rd_chk("R4 rx bin count", 4'd10, 1'b0, 32'd1);
        rd_chk("R2 tx after clear", 4'd0, 1'b0, 32'd3);
        rd_chk("R2 tx frames after clear", 4'd4, 1'b0, 32'd1);

        // R9 and R5: test write and the low/high pair
        wr(4'd1, 32'h0000ABCD);
        wr(4'd0, 32'h12345678);
        rd_chk("R9 low word written", 4'd0, 1'b0, 32'h12345678);
        @(negedge clk); tx_oct_amt = 4'd7;
        @(negedge clk); tx_oct_amt = 4'd0;
        rd_chk("R5 held high word", 4'd1, 1'b0, 32'h0000ABCD);
        rd_chk("R5 pair released", 4'd1, 1'b0, 32'h0);
        rd_chk("R5 unpaired rx high", 4'd3, 1'b0, 32'h0);
        rd_chk("R2 cleared 48-bit", 4'd0, 1'b0, 32'd7);
        rd_chk("R5 high of small value", 4'd1, 1'b0, 32'h0);
        wr(4'd3, 32'h00000055);
        wr(4'd2, 32'h00000001);
        rd_chk("R9 rx low written", 4'd2, 1'b0, 32'h1);
        rd_chk("R5 event read between", 4'd4, 1'b0, 32'h0);
        rd_chk("R5 rx high kept", 4'd3, 1'b0, 32'h55);

        // R3 and R8: saturation pushed by test increments
        rx_en = 1'b0;
        for (int a = 4; a < 16; a++) wr(a[3:0], 32'hFFFFFFFE);
        for (int n = 0; n < 3; n++) begin
            @(negedge clk); test_inc = 1'b1;
            @(negedge clk); test_inc = 1'b0;
        end
        for (int a = 4; a < 16; a++) rd_chk("R3 event saturates", a[3:0], 1'b0, 32'hFFFFFFFF);
        rd_chk("R8 tx octets test inc", 4'd0, 1'b0, 32'd3);
        rd_chk("R8 rx octets test inc with rx off", 4'd2, 1'b0, 32'd3);
        @(negedge clk); test_inc = 1'b1;
        @(negedge clk); test_inc = 1'b0;
        rd_chk("R8 rx frames test inc", 4'd5, 1'b0, 32'd1);
        rd_chk("R8 last bin test inc", 4'd15, 1'b0, 32'd1);
        rd_chk("R8 tx octets single inc", 4'd0, 1'b0, 32'd1);
        rd_chk("R8 rx octets single inc", 4'd2, 1'b0, 32'd1);
        for (int a = 4; a < 16; a++) begin
            if (a != 5 && a != 15) rd(a[3:0], 1'b0, d);
        end
        wr(4'd1, 32'h0000FFFF);
        wr(4'd0, 32'hFFFFFFFD);
        @(negedge clk); tx_oct_amt = 4'd7;
        @(negedge clk); tx_oct_amt = 4'd0;
        rd_chk("R3 octet low saturates", 4'd0, 1'b0, 32'hFFFFFFFF);
        rd_chk("R3 octet high saturates", 4'd1, 1'b0, 32'h0000FFFF);

        // R11: strobe in the same cycle as the clearing read
        @(negedge clk); tx_ok_stb = 1'b1;
        repeat (4) @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'd4;
        @(negedge clk);
        bus_rd = 1'b0; tx_ok_stb = 1'b0;
        check("R11 read value before", {16'h0, bus_rdata}, 48'd4);
        rd_chk("R11 strobe survives clear", 4'd4, 1'b0, 32'd1);

        // R6 and R7: snapshot then shadow reads
        rx_en = 1'b1;
        @(negedge clk); tx_ok_stb = 1'b1;
        repeat (3) @(negedge clk);
        tx_ok_stb = 1'b0; rx_ok_stb = 1'b1; tx_oct_amt = 4'd9;
        @(negedge clk); tx_oct_amt = 4'd0;
        @(negedge clk); rx_ok_stb = 1'b0;
        wr(4'd3, 32'h00000077);
        @(negedge clk); snap_req = 1'b1;
        @(negedge clk); snap_req = 1'b0;
        rd_chk("R7 shadow tx frames", 4'd4, 1'b1, 32'd3);
        rd_chk("R7 shadow read no clear", 4'd4, 1'b1, 32'd3);
        rd_chk("R7 shadow rx frames", 4'd5, 1'b1, 32'd2);
        rd_chk("R7 shadow tx octets", 4'd0, 1'b1, 32'd9);
        rd_chk("R7 shadow tx high", 4'd1, 1'b1, 32'd0);
        rd_chk("R7 shadow rx octets", 4'd2, 1'b1, 32'd0);
        rd_chk("R7 shadow rx high", 4'd3, 1'b1, 32'h77);
        rd_chk("R6 live tx frames cleared", 4'd4, 1'b0, 32'd0);
        rd_chk("R6 live rx frames cleared", 4'd5, 1'b0, 32'd0);
        rd_chk("R6 live tx octets cleared", 4'd0, 1'b0, 32'd0);
        rd_chk("R6 live rx octets cleared", 4'd2, 1'b0, 32'd0);
        rd_chk("R6 live rx high cleared", 4'd3, 1'b0, 32'd0);
        rd_chk("R7 shadow kept", 4'd4, 1'b1, 32'd3);

        @(negedge clk);
        check("R1 idle rvalid", {47'h0, bus_rvalid}, 48'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule